// File: doc/BRIEF.md
# Calendar Real-Time Clock Counter

This block keeps wall-clock time and a calendar, counting from a 32.768 kHz timebase. A prescaler divides the timebase clock down to one-second steps. Each step advances a chain of BCD fields: seconds, minutes, hours, day of week, date, month and a two-digit year. A field carries into the next one when it rolls over. Date rollover follows the length of the current month, and February gains a 29th day in years whose value is divisible by four, which holds through year 2099.

Software sees the fields through a plain register bus. The write side is a one-cycle strobe with an address and a byte. The read side is a combinational mux that selects on a separate read address. A control bit switches the hours field between 24-hour encoding and 12-hour encoding with a PM flag. The hour is stored internally in 24-hour form, so switching the bit changes only how the hour is encoded on the bus. After reset, which models the loss of all power, the clock holds still until the host writes one of the time fields. Every time-field write restarts the sub-second count. A one-cycle `sec_tick` pulse lets neighbouring logic follow each second.

Top module: `rtc_calendar_top`

## Requirements
- R1: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year and 7 control, where bit 0 of control set to 1 selects 12-hour mode. `rd_data` shows the register at `rd_addr` in the same cycle. A write becomes visible after the clock edge that accepts it.
- R2: After reset, seconds, minutes, hours, day of week and year read 0x00, date and month read 0x01, control reads 0x00, and `sec_tick` is low.
- R3: After reset no field advances until a write to address 0 to 6 is accepted. A write to the control register alone does not start counting.
- R4: While running, the seconds field advances once every `PRESC_DIV` clock cycles. A write to address 0 to 6 restarts that count: the first advance comes `PRESC_DIV` cycles after the accepting edge, and an advance that falls on the write cycle is dropped.
- R5: `sec_tick` is high for exactly one cycle: the cycle in which the new seconds value first reads back.
- R6: Seconds and minutes count 00 to 59 in BCD and carry when they wrap. In 24-hour mode, hours count 00 to 23 and carry into the day fields when they wrap.
- R7: The date counts from 01 up to 30 in April, June, September and November, and up to 31 in the other months except February. On wrap it returns to 01 and the month advances.
- R8: February ends at 29 when the year value is divisible by 4 and at 28 otherwise. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R9: The day of week counts 0 to 6, advances at every midnight and wraps from 6 to 0, whatever the date does.
- R10: In 12-hour mode, bit 5 of the hours register is the PM flag and bits 4:0 hold a BCD hour from 1 to 12, with 12 AM as midnight. Writes to the hours register use the same encoding. The count goes 11 AM to 12 PM and 11 PM to 12 AM, and the second of these starts a new day.
- R11: Changing the control bit re-encodes the current hour for reading and does not change the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Active-low reset; models loss of all power |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data (BCD for time fields) |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Register selected by rd_addr |
| sec_tick | output | 1 | One-cycle pulse per second advance |

## Verification
The bench overrides `PRESC_DIV` to 4, so one second lasts four clock cycles. At that rate every rollover runs out in a few dozen cycles: minute and midnight carries, the 30-day and 31-day month ends, February in leap and common years, and the wrap from year 99 to 00. This is only after the host loads a time just short of each boundary. With the short second, restarting the count on a write and dropping an advance that falls on a write cycle happen many times in one run, and the behavioural model checks the exact tick cycle every time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 7;
  localparam int AW     = 3;
  localparam logic [AW-1:0] A_HOUR = 3'd2;
  localparam logic [AW-1:0] A_CTRL = 3'd7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] b);
    logic [6:0] t;
    logic [6:0] o;
    t = b / 7'd10;
    o = b - t * 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // 24-hour BCD hour -> 12-hour register encoding (bit 5 = PM)
  function automatic logic [7:0] hour_to12(input logic [7:0] h24);
    logic [6:0] b;
    b = bcd2bin(h24);
    if (b == 7'd0)  return 8'h12;
    if (b < 7'd12)  return bin2bcd(b);
    if (b == 7'd12) return 8'h32;
    return 8'h20 | bin2bcd(b - 7'd12);
  endfunction

  // 12-hour register encoding -> 24-hour BCD hour
  function automatic logic [7:0] hour_from12(input logic [7:0] r);
    logic [6:0] b;
    b = (r[4] ? 7'd10 : 7'd0) + 7'(r[3:0]);
    if (b == 7'd12) return r[5] ? 8'h12 : 8'h00;
    return r[5] ? bin2bcd(b + 7'd12) : bin2bcd(b);
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic inc
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  assign inc = run && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (run) begin
      if (cnt == LAST)     cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] LO  = 8'h00,
  parameter logic [7:0] RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       step,
  input  logic [7:0] hi,
  output logic [7:0] value,
  output logic       carry
);
  import rtc_pkg::*;

  assign carry = step && !wr && (value == hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= RST;
    else if (wr)   value <= wdata;
    else if (step) value <= (value == hi) ? LO : bcd_inc(value);
  end
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top #(
  parameter int PRESC_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sec_tick
);
  import rtc_pkg::*;

  logic             running;
  logic             mode12;
  logic             time_wr;
  logic             inc;
  logic [7:0]       field_val [NFIELD];
  logic [7:0]       field_hi  [NFIELD];
  logic             field_cy  [NFIELD];
  logic             field_st  [NFIELD];
  logic             field_wr  [NFIELD];
  logic [7:0]       field_wd  [NFIELD];

  assign time_wr = wr_en && (wr_addr != A_CTRL);

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(running), .clr(time_wr), .inc(inc)
  );

  // carry chain: sec -> min -> hour -> {dow, date} ; date -> month -> year
  always_comb begin
    field_st[0] = inc;
    field_st[1] = field_cy[0];
    field_st[2] = field_cy[1];
    field_st[3] = field_cy[2];
    field_st[4] = field_cy[2];
    field_st[5] = field_cy[4];
    field_st[6] = field_cy[5];
    field_hi[0] = 8'h59;
    field_hi[1] = 8'h59;
    field_hi[2] = 8'h23;
    field_hi[3] = 8'h06;
    field_hi[4] = month_last(field_val[5], field_val[6]);
    field_hi[5] = 8'h12;
    field_hi[6] = 8'h99;
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    localparam logic [7:0] LO_I = (i == 4 || i == 5) ? 8'h01 : 8'h00;
    assign field_wr[i] = wr_en && (wr_addr == 3'(i));
    if (i == 2) begin : g_hour
      assign field_wd[i] = mode12 ? hour_from12(wr_data) : wr_data;
    end else begin : g_plain
      assign field_wd[i] = wr_data;
    end
    rtc_bcd_field #(.LO(LO_I), .RST(LO_I)) u_fld (
      .clk(clk), .rst_n(rst_n), .wr(field_wr[i]), .wdata(field_wd[i]),
      .step(field_st[i]), .hi(field_hi[i]), .value(field_val[i]), .carry(field_cy[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      mode12   <= 1'b0;
      sec_tick <= 1'b0;
    end else begin
      running  <= running | time_wr;
      sec_tick <= inc;
      if (wr_en && wr_addr == A_CTRL) mode12 <= wr_data[0];
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd6: rd_data = field_val[rd_addr];
      3'd2:    rd_data = mode12 ? hour_to12(field_val[2]) : field_val[2];
      default: rd_data = {7'd0, mode12};
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       sec_tick,
  input logic       running,
  input logic [7:0] sec_v,
  input logic [7:0] hour_v,
  input logic [7:0] dow_v
);
  logic twr;
  assign twr = wr_en && (wr_addr != 3'd7);

  // R5: tick never lasts two cycles
  p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R3: frozen clock neither moves seconds nor ticks
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !twr) |=> ($stable(sec_v) && !sec_tick));

  // R4: a time write drops any pending advance
  p_write_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    twr |=> !sec_tick);

  // R6: each tick coincides with a new seconds value
  p_tick_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (sec_v != $past(sec_v)));

  // R9: midnight advances the day of week
  p_midnight_dow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hour_v) == 8'h23 && hour_v == 8'h00 && !$past(twr)) |-> (dow_v != $past(dow_v)));
endmodule

bind rtc_calendar_top rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .sec_tick(sec_tick),
  .running(running), .sec_v(field_val[0]), .hour_v(field_val[2]), .dow_v(field_val[3])
);

// File: tb/rtc_calendar_top_bench.sv
module rtc_calendar_top_bench;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       sec_tick;

  logic [2:0] scan_addr = '0;
  logic [2:0] force_addr = '0;
  logic       use_force = 1'b0;
  assign rd_addr = use_force ? force_addr : scan_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_pc;
  bit m_run, m_m12, m_tick;

  rtc_calendar_top #(.PRESC_DIV(DIV)) u_rtc_calendar_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int unbcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] tobcd(input int b);
    return {4'(b / 10), 4'(b % 10)};
  endfunction
  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] enc_hour(input int h, input bit m12);
    if (!m12) return tobcd(h);
    if (h == 0) return 8'h12;
    if (h < 12) return tobcd(h);
    if (h == 12) return 8'h32;
    return 8'h20 | tobcd(h - 12);
  endfunction
  function automatic logic [7:0] exp_reg(input logic [2:0] a);
    case (a)
      3'd0: return tobcd(m_sec);
      3'd1: return tobcd(m_min);
      3'd2: return enc_hour(m_hr, m_m12);
      3'd3: return tobcd(m_dow);
      3'd4: return tobcd(m_date);
      3'd5: return tobcd(m_mon);
      3'd6: return tobcd(m_yr);
      default: return {7'd0, m_m12};
    endcase
  endfunction
  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1: return "R6";
      3'd2: return m_m12 ? "R10" : "R6";
      3'd3: return "R9";
      3'd4: return "R7";
      3'd5, 3'd6: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp_v, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_dow = 0; m_date = 1; m_mon = 1; m_yr = 0;
      m_pc = 0; m_run = 0; m_m12 = 0; m_tick = 0;
    end else begin
      bit tw, adv;
      tw  = wr_en && wr_addr != 3'd7;
      adv = m_run && m_pc == DIV - 1 && !tw;
      m_tick = adv;
      if (tw) m_pc = 0;
      else if (m_run) m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
      if (adv) begin
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
              m_hr = 0; m_dow = (m_dow + 1) % 7; m_date++;
              if (m_date > mdays(m_mon, m_yr)) begin
                m_date = 1; m_mon++;
                if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
              end
            end
          end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_sec = unbcd(wr_data);
          3'd1: m_min = unbcd(wr_data);
          3'd2: begin
            if (m_m12) begin
              int b;
              b = (wr_data[4] ? 10 : 0) + int'(wr_data[3:0]);
              if (b == 12) m_hr = wr_data[5] ? 12 : 0;
              else m_hr = wr_data[5] ? b + 12 : b;
            end else m_hr = unbcd(wr_data);
          end
          3'd3: m_dow = unbcd(wr_data);
          3'd4: m_date = unbcd(wr_data);
          3'd5: m_mon = unbcd(wr_data);
          3'd6: m_yr = unbcd(wr_data);
          default: m_m12 = wr_data[0];
        endcase
      end
      if (tw) m_run = 1;
    end
  end

  always @(posedge clk) #1 scan_addr <= scan_addr + 3'd1;

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of(rd_addr), int'(rd_data), int'(exp_reg(rd_addr)));
      chk("R5", int'(sec_tick), int'(m_tick));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2;
    force_addr = a; use_force = 1'b1;
    @(negedge clk);
    chk(tag, int'(rd_data), int'(e));
    use_force = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] yr, mon, date, dow, hr, mi, se);
    wr(3'd6, yr); wr(3'd5, mon); wr(3'd4, date); wr(3'd3, dow);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2 reset state
    rd_chk(3'd0, 8'h00, "R2"); rd_chk(3'd2, 8'h00, "R2"); rd_chk(3'd4, 8'h01, "R2");
    rd_chk(3'd5, 8'h01, "R2"); rd_chk(3'd6, 8'h00, "R2"); rd_chk(3'd7, 8'h00, "R2");
    @(negedge clk); chk("R2", int'(sec_tick), 0);
    // R3 frozen until a time write; control write does not start it
    wait_cyc(40); rd_chk(3'd0, 8'h00, "R3");
    wr(3'd7, 8'h00); wait_cyc(20); rd_chk(3'd0, 8'h00, "R3");
    // R4 first advance DIV cycles after the write edge
    begin
      int n;
      wr(3'd0, 8'h10);
      n = 0;
      while (n < 50) begin
        @(negedge clk); n++;
        if (sec_tick) break;
      end
      chk("R4", n - 1, DIV);
      rd_chk(3'd0, 8'h11, "R4");
    end
    // R6 minute carry
    wr(3'd0, 8'h57); wait_cyc(4 * DIV + 2); rd_chk(3'd1, 8'h01, "R6");
    // R1 write visibility
    wr(3'd1, 8'h42); rd_chk(3'd1, 8'h42, "R1");
    // R7 30-day month end
    set_time(8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd4, 8'h01, "R7"); rd_chk(3'd5, 8'h05, "R7");
    rd_chk(3'd3, 8'h03, "R9");
    // R7 31-day month
    set_time(8'h23, 8'h05, 8'h30, 8'h02, 8'h23, 8'h59, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd4, 8'h31, "R7");
    // R8 leap and common February, year wrap
    set_time(8'h24, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd4, 8'h29, "R8");
    set_time(8'h24, 8'h02, 8'h29, 8'h00, 8'h23, 8'h59, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd5, 8'h03, "R8");
    set_time(8'h23, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd4, 8'h01, "R8"); rd_chk(3'd5, 8'h03, "R8");
    set_time(8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd6, 8'h00, "R8"); rd_chk(3'd5, 8'h01, "R8");
    // R9 weekday wrap
    set_time(8'h30, 8'h06, 8'h10, 8'h06, 8'h23, 8'h59, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd3, 8'h00, "R9");
    // R11 mode switch re-encodes
    wr(3'd2, 8'h23); wr(3'd7, 8'h01);
    rd_chk(3'd2, 8'h31, "R11"); rd_chk(3'd7, 8'h01, "R1");
    // R10 12-hour counting
    wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd2, 8'h32, "R10");
    wr(3'd3, 8'h02); wr(3'd2, 8'h31); wr(3'd1, 8'h59); wr(3'd0, 8'h58);
    wait_cyc(3 * DIV); rd_chk(3'd2, 8'h12, "R10"); rd_chk(3'd3, 8'h03, "R10");
    wr(3'd7, 8'h00); rd_chk(3'd2, 8'h00, "R11");
    wait_cyc(5 * DIV);
    finish_run();
  end
endmodule